// File: doc/BRIEF.md
# Converter Start-Up and Protection Sequencer

This block is the control state machine that sits in front of a PWM generator for a bidirectional buck/boost converter. It combines the enable request, the external fault line, and two on-chip monitors (input voltage and die temperature, each arriving as a digital code) into one run condition. While the converter runs, the block holds a frozen copy of the buck/boost selection. It also drives a digital soft-start ceiling that limits the duty cycle during start-up.

The soft-start ceiling is a counter. It starts climbing only when the internal regulator reports that it is ready, and it advances one step every programmable number of clocks. It saturates at full scale. Every stop condition discharges the ramp to zero, and so does a hiccup request from the current-limit logic, so each restart begins a fresh ramp. Switching is held off until the ramp leaves a low dead zone. Once the ramp crosses a high threshold, the block raises a flag that moves the PWM generator from diode-assisted operation into fully synchronous operation.

Top module: `pwm_seq_ctrl`

## Requirements
- R1: `drive_en` is low in the same cycle in which `en_i` is low or `fault_n` is low.
- R2: With `temp_code` in degrees, thermal shutdown is entered on the first clock edge that sees `temp_code` >= 150. It is left only on an edge that sees `temp_code` <= 135. While it lasts, `drive_en` is low and the ramp stays at 0.
- R3: With `vin_code` in 10 mV steps, the supply is judged good on an edge that sees `vin_code` >= 571. It is judged bad on an edge that sees `vin_code` < 534. Between those values the previous judgement is kept. A bad supply stops the converter.
- R4: Whenever the run condition (enable, fault_n high, supply good, no thermal shutdown) is false at a clock edge, `ss_level` is 0 after that edge.
- R5: While `reg_ready` is low, `ss_level` does not leave 0.
- R6: With `ramp_div` = N > 0, `ss_level` increases by one every N clocks of running with the regulator ready. It saturates at 2^RAMP_W-1 (255 by default).
- R7: With `ramp_div` = 0, `ss_level` reaches full scale on the first running clock edge.
- R8: `drive_en` is high only while running with `ss_level` >= 27 (about 0.52/5 of full scale). `ss_done` is high only while running with `ss_level` >= 230 (4.5/5 of full scale).
- R9: `mode_q` (1 = buck, 0 = boost; 0 after reset) takes the value of `mode_in` on the clock edge at which the run condition first becomes true. This covers enable rising and fault release.
- R10: While the converter keeps running, changes on `mode_in` do not change `mode_q`.
- R11: A high `hiccup_req` at a clock edge leaves `ss_level` at 0. After the request drops, the ramp climbs again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enable request |
| fault_n | input | 1 | External fault, active low |
| vin_code | input | VIN_W (13) | Input voltage code, 10 mV per step |
| temp_code | input | TEMP_W (8) | Die temperature code, degrees |
| reg_ready | input | 1 | Internal regulator has reached 90 % of its target |
| mode_in | input | 1 | Requested mode, 1 = buck, 0 = boost |
| hiccup_req | input | 1 | Current-limit hiccup request |
| ramp_div | input | DIV_W (8) | Clocks per ramp step, 0 = no slope |
| mode_q | output | 1 | Latched mode |
| drive_en | output | 1 | Allow PWM switching |
| ss_level | output | RAMP_W (8) | Soft-start duty ceiling |
| ss_done | output | 1 | Soft start complete, synchronous operation |

## Verification
The bench builds the block with its default parameters: an 8-bit ramp, 13-bit voltage code and 8-bit temperature code. With these widths the whole ramp from 0 to saturation fits in a few hundred clocks, and both the switching threshold (27) and the synchronous threshold (230) can be hit on the exact cycle with a step rate of one. A step rate of three checks that the step divider counts correctly. A rate of zero checks the jump to full scale. The voltage and temperature codes are walked through the bands between their two thresholds, so that the held judgement is seen in both directions.

// File: rtl/seq_pkg.sv
// Package: shared constants for the start-up sequencer.
// Assumes mode encoding 1 = buck, 0 = boost.
package seq_pkg;
    localparam logic MODE_BUCK  = 1'b1;
    localparam logic MODE_BOOST = 1'b0;
endpackage

// File: rtl/seq_hyst_flag.sv
// Module: seq_hyst_flag
// Registers a flag from a digitized analog code, with hysteresis.
// The flag sets when code >= SET_AT and clears when code <= CLR_AT.
// Assumes CLR_AT < SET_AT. The flag resets to 0.
module seq_hyst_flag #(
    parameter int W      = 8,
    parameter int SET_AT = 150,
    parameter int CLR_AT = 135
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    output logic         flag
);
    localparam logic [W-1:0] SET_C = W'(SET_AT);
    localparam logic [W-1:0] CLR_C = W'(CLR_AT);

    // Purpose: update the flag only when a threshold is crossed.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag <= 1'b0;
        else if (code >= SET_C)  flag <= 1'b1;
        else if (code <= CLR_C)  flag <= 1'b0;
    end
endmodule

// File: rtl/seq_ss_ramp.sv
// Module: seq_ss_ramp
// Digital soft-start ramp. It holds at 0 while clear is high. When advance is
// high, it steps up once every div clocks and saturates at full scale.
// A div of 0 sets full scale at once. Assumes clear takes priority.
module seq_ss_ramp #(
    parameter int RAMP_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [DIV_W-1:0]  div,
    output logic [RAMP_W-1:0] level
);
    localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

    logic [DIV_W-1:0] pre_cnt;

    // Purpose: prescaler and saturating ramp counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            level   <= '0;
            pre_cnt <= '0;
        end else if (advance) begin
            if (div == '0) begin
                level   <= FULL;
                pre_cnt <= '0;
            end else if (pre_cnt == div - 1'b1) begin
                pre_cnt <= '0;
                if (level != FULL) level <= level + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_seq_ctrl.sv
// Module: pwm_seq_ctrl (top)
// Start-up and protection sequencer for a bidirectional PWM converter. It
// forms the run condition from enable, fault, supply and thermal monitors,
// latches the mode on each start, runs the soft-start ramp and derives the
// switching and synchronous-mode flags from it.
// Assumes all inputs are synchronous to clk and free of glitches.
module pwm_seq_ctrl #(
    parameter int VIN_W   = 13,
    parameter int TEMP_W  = 8,
    parameter int RAMP_W  = 8,
    parameter int DIV_W   = 8,
    parameter int UV_RISE = 571,
    parameter int UV_FALL = 534,
    parameter int OT_TRIP = 150,
    parameter int OT_REL  = 135
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              fault_n,
    input  logic [VIN_W-1:0]  vin_code,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              reg_ready,
    input  logic              mode_in,
    input  logic              hiccup_req,
    input  logic [DIV_W-1:0]  ramp_div,
    output logic              mode_q,
    output logic              drive_en,
    output logic [RAMP_W-1:0] ss_level,
    output logic              ss_done
);
    import seq_pkg::*;

    localparam int FULL_I = (1 << RAMP_W) - 1;
    localparam logic [RAMP_W-1:0] SW_ON   = RAMP_W'((FULL_I * 52 + 499) / 500);
    localparam logic [RAMP_W-1:0] SYNC_ON = RAMP_W'((FULL_I * 9 + 9) / 10);

    logic vin_ok;
    logic hot;
    logic run;
    logic run_q;

    seq_hyst_flag #(.W(VIN_W), .SET_AT(UV_RISE), .CLR_AT(UV_FALL - 1)) u_uv (
        .clk(clk), .rst_n(rst_n), .code(vin_code), .flag(vin_ok)
    );

    seq_hyst_flag #(.W(TEMP_W), .SET_AT(OT_TRIP), .CLR_AT(OT_REL)) u_ot (
        .clk(clk), .rst_n(rst_n), .code(temp_code), .flag(hot)
    );

    // Purpose: run condition from all enables and protections.
    always_comb run = en_i && fault_n && vin_ok && !hot;

    seq_ss_ramp #(.RAMP_W(RAMP_W), .DIV_W(DIV_W)) u_ramp (
        .clk(clk), .rst_n(rst_n),
        .clear(!run || hiccup_req),
        .advance(reg_ready),
        .div(ramp_div),
        .level(ss_level)
    );

    // Purpose: remember run and latch the mode on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= MODE_BOOST;
        end else begin
            run_q <= run;
            if (run && !run_q) mode_q <= mode_in;
        end
    end

    // Purpose: switching and synchronous flags from the ramp level.
    always_comb begin
        drive_en = run && (ss_level >= SW_ON);
        ss_done  = run && (ss_level >= SYNC_ON);
    end
endmodule

// File: rtl/pwm_seq_ctrl_chk.sv
// Module: pwm_seq_ctrl_chk
// Property checker for pwm_seq_ctrl, bound to every instance of it.
module pwm_seq_ctrl_chk #(
    parameter int RAMP_W = 8,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              fault_n,
    input logic              reg_ready,
    input logic              hiccup_req,
    input logic [DIV_W-1:0]  ramp_div,
    input logic              mode_q,
    input logic              drive_en,
    input logic [RAMP_W-1:0] ss_level,
    input logic              ss_done
);
    localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

    assert_stop_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || !fault_n) |-> !drive_en);

    assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ss_level == '0);

    assert_wait_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_ready && ss_level == '0) |=> ss_level == '0);

    assert_ramp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_level != '0 && ss_level != FULL && ramp_div != '0 && !hiccup_req)
        |=> (ss_level == '0 || ss_level == $past(ss_level) || ss_level == $past(ss_level) + 1'b1));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_level == FULL && en_i && fault_n && !hiccup_req && drive_en)
        |=> (ss_level == FULL || ss_level == '0));

    assert_done_implies_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> drive_en);

    assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(drive_en)) |-> $stable(mode_q));

    assert_hiccup_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hiccup_req |=> ss_level == '0);
endmodule

bind pwm_seq_ctrl pwm_seq_ctrl_chk #(.RAMP_W(RAMP_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .fault_n(fault_n),
    .reg_ready(reg_ready), .hiccup_req(hiccup_req), .ramp_div(ramp_div),
    .mode_q(mode_q), .drive_en(drive_en), .ss_level(ss_level), .ss_done(ss_done)
);

// File: tb/test_pwm_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwm_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        fault_n = 1'b1;
    logic [12:0] vin_code = 13'd600;
    logic [7:0]  temp_code = 8'd25;
    logic        reg_ready = 1'b1;
    logic        mode_in = 1'b0;
    logic        hiccup_req = 1'b0;
    logic [7:0]  ramp_div = 8'd1;
    logic        mode_q;
    logic        drive_en;
    logic [7:0]  ss_level;
    logic        ss_done;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_seq_ctrl i_pwm_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .fault_n(fault_n),
        .vin_code(vin_code), .temp_code(temp_code), .reg_ready(reg_ready),
        .mode_in(mode_in), .hiccup_req(hiccup_req), .ramp_div(ramp_div),
        .mode_q(mode_q), .drive_en(drive_en), .ss_level(ss_level), .ss_done(ss_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("reset level", ss_level, 0);
        check("reset drive", drive_en, 0);
        check("reset done", ss_done, 0);
        check("reset mode", mode_q, 0);
    endtask

    task automatic t_ramp_up;   // R6 R8 R9
        mode_in = 1'b1; ramp_div = 8'd1; en_i = 1'b1;
        step(10);
        check("R6 level after 10", ss_level, 10);
        check("R9 mode latched buck", mode_q, 1);
        step(16);
        check("R8 level 26", ss_level, 26);
        check("R8 no drive below 27", drive_en, 0);
        step(1);
        check("R8 drive at 27", drive_en, 1);
        step(202);
        check("R8 level 229", ss_level, 229);
        check("R8 not done at 229", ss_done, 0);
        step(1);
        check("R8 done at 230", ss_done, 1);
        step(40);
        check("R6 saturated", ss_level, 255);
    endtask

    task automatic t_mode_ignored;   // R10
        mode_in = 1'b0;
        step(5);
        check("R10 mode kept", mode_q, 1);
        check("R10 still running", ss_level, 255);
    endtask

    task automatic t_fault;   // R1 R4 R9
        fault_n = 1'b0;
        #1;
        check("R1 fault drive off", drive_en, 0);
        step(1);
        check("R4 fault clears ramp", ss_level, 0);
        fault_n = 1'b1;
        step(1);
        check("R9 mode on fault release", mode_q, 0);
        check("R9 ramp restarted", ss_level, 1);
    endtask

    task automatic t_disable;   // R1 R4
        step(30);
        check("R8 drive at 31", drive_en, 1);
        en_i = 1'b0;
        #1;
        check("R1 disable drive off", drive_en, 0);
        step(1);
        check("R4 disable clears", ss_level, 0);
        step(3);
        check("R4 stays clear", ss_level, 0);
    endtask

    task automatic t_ready;   // R5 R9
        reg_ready = 1'b0; mode_in = 1'b1; en_i = 1'b1;
        step(5);
        check("R5 hold without regulator", ss_level, 0);
        check("R9 mode on enable", mode_q, 1);
        reg_ready = 1'b1;
        step(4);
        check("R5 ramp after ready", ss_level, 4);
    endtask

    task automatic t_div;   // R6
        en_i = 1'b0; step(1);
        ramp_div = 8'd3; en_i = 1'b1;
        step(6);
        check("R6 div3 after 6", ss_level, 2);
        step(2);
        check("R6 div3 after 8", ss_level, 2);
        step(1);
        check("R6 div3 after 9", ss_level, 3);
    endtask

    task automatic t_jump;   // R7
        en_i = 1'b0; step(1);
        ramp_div = 8'd0; en_i = 1'b1;
        step(1);
        check("R7 jump to full", ss_level, 255);
        check("R7 done at once", ss_done, 1);
    endtask

    task automatic t_hiccup;   // R11
        hiccup_req = 1'b1;
        step(1);
        check("R11 hiccup clears", ss_level, 0);
        check("R11 hiccup drive off", drive_en, 0);
        hiccup_req = 1'b0; ramp_div = 8'd1;
        step(5);
        check("R11 restart", ss_level, 5);
    endtask

    task automatic t_thermal;   // R2
        temp_code = 8'd150;
        step(1);
        check("R2 trip drive off", drive_en, 0);
        step(1);
        check("R2 ramp cleared", ss_level, 0);
        temp_code = 8'd140;
        step(3);
        check("R2 held in band", ss_level, 0);
        temp_code = 8'd135;
        step(2);
        check("R2 released", ss_level, 1);
    endtask

    task automatic t_uv;   // R3
        vin_code = 13'd550;
        step(3);
        check("R3 ok kept in band", ss_level, 4);
        vin_code = 13'd530;
        step(2);
        check("R3 low trips", ss_level, 0);
        vin_code = 13'd560;
        step(3);
        check("R3 bad kept in band", ss_level, 0);
        vin_code = 13'd571;
        step(2);
        check("R3 recovered", ss_level, 1);
    endtask

    initial begin
        step(3);
        t_reset;
        rst_n = 1'b1;
        step(2);
        t_ramp_up;
        t_mode_ignored;
        t_fault;
        t_disable;
        t_ready;
        t_div;
        t_jump;
        t_hiccup;
        t_thermal;
        t_uv;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule